// File: doc/BRIEF.md
# ECC RAM Wrapper with Read-Path Fault Injection

This block wraps a synchronous single-port word memory. Every stored word carries SECDED check bits that are computed on each write. Each read is decoded before it reaches the requester. A single flipped bit is repaired in the returned word. A double flip is reported as uncorrectable, and that report is meant to trap the requester synchronously.

A fault-injection stage sits between the memory array and the decoder. When it is armed, it inverts a chosen set of data bits and check bits in the word taken from the array. The stored cell is never changed. Turning injection off therefore makes the very next read clean again.

Correctable and uncorrectable events are logged separately. Each log keeps a sticky flag and the address of the first event it saw. Each log drives an interrupt through its own enable. Software clears a log by pulsing its clear input.

Requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is pending or the pending response is being taken in the same cycle. A read response stays on the output, unchanged, until `rsp_ready` is high. Writes produce no response.

Top module: `ecc_ram_inj`

## Requirements
- R1: A read accepted at edge N presents the last data written to that address on `rsp_data`, with `rsp_valid` high, after edge N. With no injection, `rsp_cerr` and `rsp_uerr` are both 0. Each write re-encodes the check bits, so rewriting a word stores fresh, clean check bits.
- R2: When injection is enabled and exactly one bit is set across `inj_data_mask` (data bits 31..0) and `inj_chk_mask` (check bits 6..0), the read returns the correct stored data with `rsp_cerr`=1 and `rsp_uerr`=0.
- R3: When injection is enabled and exactly two distinct bits are set across the two masks, the read gives `rsp_uerr`=1 and `rsp_cerr`=0.
- R4: Injection never modifies the array. After `inj_enable` is cleared, the next read of any address returns the stored data with no error indication.
- R5: A read flagged correctable sets `ce_flag` and loads `ce_addr` one edge after the response appears. An uncorrectable read does the same with `ue_flag` and `ue_addr`. While a flag is set, later events leave the captured address unchanged (first error wins). Turning injection off does not clear a flag.
- R6: A one-cycle pulse on `ce_clr` or `ue_clr` clears the matching flag. If a new event of that type is logged on the same edge as the clear, the flag stays set and captures the new address.
- R7: `ce_irq` equals `ce_flag` AND `ce_irq_en`. `ue_irq` equals `ue_flag` AND `ue_irq_en`. An uncorrectable event never sets `ce_flag`, and a correctable one never sets `ue_flag`.
- R8: `req_ready` = NOT `rsp_valid` OR `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response holds its values.
- R9: After reset, `rsp_valid`, both flags and both interrupts are 0, both captured addresses are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 32 | Corrected read data |
| rsp_cerr | output | 1 | Response had a corrected single-bit error |
| rsp_uerr | output | 1 | Response is uncorrectable (synchronous exception) |
| inj_enable | input | 1 | Arms read-path injection |
| inj_data_mask | input | 32 | Data bits to invert on read |
| inj_chk_mask | input | 7 | Check bits to invert on read |
| ce_irq_en | input | 1 | Correctable interrupt enable |
| ue_irq_en | input | 1 | Uncorrectable interrupt enable |
| ce_clr | input | 1 | Clear pulse for the correctable log |
| ue_clr | input | 1 | Clear pulse for the uncorrectable log |
| ce_flag | output | 1 | Sticky correctable flag |
| ce_addr | output | ADDR_W | Address of first correctable event |
| ue_flag | output | 1 | Sticky uncorrectable flag |
| ue_addr | output | ADDR_W | Address of first uncorrectable event |
| ce_irq | output | 1 | Correctable interrupt |
| ue_irq | output | 1 | Uncorrectable interrupt |

## Verification
The decoder is tried with every single-bit flip over all 39 stored bits. This separates repair of data positions from flips that land only in check bits or in the overall parity bit. It is then tried with every distinct pair of flipped bits, all 741 of them. A pair that aliases to a wrong repair would surface as a false correctable report.

The clean sweeps run before and after injection. They show that the array itself was never disturbed and that the logs keep their first-captured addresses. A clear that coincides with a new event, and a response stalled by back-pressure, cover the two timing races of the block.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;
  localparam int DW   = 32;          // data bits per word
  localparam int HW   = 6;           // Hamming syndrome bits
  localparam int CW   = HW + 1;      // plus overall parity
  localparam int NPOS = DW + HW;     // Hamming positions 1..NPOS
  localparam int SW   = DW + CW;     // stored word width

  // Codeword position of data bit i (positions that are not powers of two).
  function automatic int data_pos(input int i);
    int k;
    int p;
    k = -1;
    p = 0;
    for (int q = 1; q <= NPOS; q++) begin
      if ((q & (q - 1)) != 0) begin
        k++;
        if (k == i) p = q;
      end
    end
    return p;
  endfunction

  // XOR of the positions of all set data bits.
  function automatic logic [HW-1:0] ham_bits(input logic [DW-1:0] d);
    logic [HW-1:0] s;
    s = '0;
    for (int i = 0; i < DW; i++)
      if (d[i]) s ^= HW'(data_pos(i));
    return s;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import ecc_ram_pkg::*;
(
  input  logic [DW-1:0] data,
  output logic [CW-1:0] chk
);
  logic [HW-1:0] ham;

  always_comb begin
    ham = ham_bits(data);
    chk = {(^data) ^ (^ham), ham};
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import ecc_ram_pkg::*;
(
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] chk,
  output logic [DW-1:0] fixed,
  output logic          cerr,
  output logic          uerr
);
  logic [HW-1:0] syn;
  logic          par;

  always_comb begin
    syn   = ham_bits(data) ^ chk[HW-1:0];
    par   = (^data) ^ (^chk);
    fixed = data;
    cerr  = 1'b0;
    uerr  = 1'b0;
    if (par) begin
      if (syn == '0) begin
        cerr = 1'b1;                 // overall parity bit itself flipped
      end else if (int'(syn) <= NPOS) begin
        cerr = 1'b1;
        for (int i = 0; i < DW; i++)
          if (data_pos(i) == int'(syn)) fixed[i] = ~data[i];
      end else begin
        uerr = 1'b1;                 // syndrome points outside the word
      end
    end else if (syn != '0) begin
      uerr = 1'b1;                   // even flips, nonzero syndrome
    end
  end
endmodule

// File: rtl/err_log.sv
module err_log #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic              clr,
  output logic              flag,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      addr <= '0;
    end else if (hit && (!flag || clr)) begin
      flag <= 1'b1;
      addr <= hit_addr;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  // R5
  first_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag && $stable(addr));

  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !hit |=> !flag);
endmodule

// File: rtl/ecc_ram_inj.sv
module ecc_ram_inj
  import ecc_ram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              rsp_cerr,
  output logic              rsp_uerr,
  input  logic              inj_enable,
  input  logic [31:0]       inj_data_mask,
  input  logic [6:0]        inj_chk_mask,
  input  logic              ce_irq_en,
  input  logic              ue_irq_en,
  input  logic              ce_clr,
  input  logic              ue_clr,
  output logic              ce_flag,
  output logic [ADDR_W-1:0] ce_addr,
  output logic              ue_flag,
  output logic [ADDR_W-1:0] ue_addr,
  output logic              ce_irq,
  output logic              ue_irq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SW-1:0]     mem [DEPTH];
  logic [CW-1:0]     wr_chk;
  logic [SW-1:0]     rd_word;
  logic [SW-1:0]     flip;
  logic [ADDR_W-1:0] rd_addr;
  logic              rsp_new;
  logic              accept;
  logic              dec_cerr;
  logic              dec_uerr;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign flip      = inj_enable ? {inj_chk_mask, inj_data_mask} : '0;

  secded_enc enc_i (.data(req_wdata), .chk(wr_chk));

  always_ff @(posedge clk) begin
    if (accept && req_we) mem[req_addr] <= {wr_chk, req_wdata};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_new   <= 1'b0;
      rd_word   <= '0;
      rd_addr   <= '0;
    end else begin
      rsp_new <= accept && !req_we;
      if (accept && !req_we) begin
        rsp_valid <= 1'b1;
        rd_word   <= mem[req_addr] ^ flip;
        rd_addr   <= req_addr;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  secded_dec dec_i (
    .data (rd_word[DW-1:0]),
    .chk  (rd_word[SW-1:DW]),
    .fixed(rsp_data),
    .cerr (dec_cerr),
    .uerr (dec_uerr)
  );

  assign rsp_cerr = rsp_valid && dec_cerr;
  assign rsp_uerr = rsp_valid && dec_uerr;

  err_log #(.ADDR_W(ADDR_W)) ce_log_i (
    .clk(clk), .rst_n(rst_n), .hit(rsp_new && dec_cerr), .hit_addr(rd_addr),
    .clr(ce_clr), .flag(ce_flag), .addr(ce_addr)
  );

  err_log #(.ADDR_W(ADDR_W)) ue_log_i (
    .clk(clk), .rst_n(rst_n), .hit(rsp_new && dec_uerr), .hit_addr(rd_addr),
    .clr(ue_clr), .flag(ue_flag), .addr(ue_addr)
  );

  assign ce_irq = ce_flag && ce_irq_en;
  assign ue_irq = ue_flag && ue_irq_en;

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_uerr) && $stable(rsp_cerr));

  // R1
  rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && !req_we));

  // R3
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_cerr && rsp_uerr));

  // R7
  ce_from_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_flag) |-> $past(rsp_valid && rsp_cerr));
endmodule

// File: tb/ecc_ram_inj_tb_top.sv
module ecc_ram_inj_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_cerr, rsp_uerr;
  logic          rsp_ready = 1'b1;
  logic [31:0]   rsp_data;
  logic          inj_enable = 1'b0;
  logic [31:0]   inj_data_mask = '0;
  logic [6:0]    inj_chk_mask = '0;
  logic          ce_irq_en = 1'b0, ue_irq_en = 1'b0, ce_clr = 1'b0, ue_clr = 1'b0;
  logic          ce_flag, ue_flag, ce_irq, ue_irq;
  logic [AW-1:0] ce_addr, ue_addr;

  int total = 0;
  int bad = 0;
  logic [31:0] model [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_ram_inj #(.ADDR_W(AW)) dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h9E3779B9) ^ 32'h5A5A00FF;
  endfunction

  task automatic do_write(input int a, input logic [31:0] d);
    req_valid = 1'b1; req_we = 1'b1; req_addr = AW'(a); req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    model[a] = d;
  endtask

  task automatic do_read(input int a);
    req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_mask(input logic [38:0] m);
    inj_data_mask = m[31:0];
    inj_chk_mask  = m[38:32];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check(!rsp_valid && req_ready, "R9", "rsp_valid/req_ready", {30'd0, rsp_valid, req_ready}, 32'd1);
    check(!ce_flag && !ue_flag && !ce_irq && !ue_irq, "R9", "flags", {28'd0, ce_flag, ue_flag, ce_irq, ue_irq}, 0);
    check(ce_addr == 0 && ue_addr == 0, "R9", "addrs", {ce_addr, ue_addr}, 0);

    for (int a = 0; a < NW; a++) do_write(a, pat(a));
    // R1 clean reads
    for (int a = 0; a < NW; a++) begin
      do_read(a);
      check(rsp_valid && rsp_data == model[a], "R1", "clean data", rsp_data, model[a]);
      check(!rsp_cerr && !rsp_uerr, "R1", "clean flags", {rsp_cerr, rsp_uerr}, 0);
    end
    @(negedge clk);
    check(!ce_flag && !ue_flag, "R1", "no log on clean", {ce_flag, ue_flag}, 0);

    // R2 every single-bit flip
    inj_enable = 1'b1;
    for (int b = 0; b < 39; b++) begin
      set_mask(39'(1) << b);
      do_read((b + 3) % NW);
      check(rsp_data == model[(b + 3) % NW], "R2", "corrected data", rsp_data, model[(b + 3) % NW]);
      check(rsp_cerr && !rsp_uerr, "R2", "single flags", {rsp_cerr, rsp_uerr}, 32'd2);
    end
    @(negedge clk);
    // R5 first error wins
    check(ce_flag && ce_addr == 3, "R5", "ce log", {ce_flag, ce_addr}, {1'b1, 4'd3});
    // R7 interrupt gating and type separation
    ue_irq_en = 1'b1;
    check(!ce_irq && !ue_flag && !ue_irq, "R7", "ce irq masked, no ue", {ce_irq, ue_flag, ue_irq}, 0);
    ce_irq_en = 1'b1;
    #1;
    check(ce_irq, "R7", "ce irq enabled", ce_irq, 1);

    // R3 every pair of flips
    for (int a = 0; a < 39; a++) begin
      for (int b = a + 1; b < 39; b++) begin
        set_mask((39'(1) << a) | (39'(1) << b));
        do_read((a + b) % NW);
        check(rsp_uerr && !rsp_cerr, "R3", "double flags", {rsp_cerr, rsp_uerr}, 32'd1);
      end
    end
    @(negedge clk);
    check(ue_flag && ue_addr == 1 && ue_irq, "R5", "ue log", {ue_flag, ue_irq, ue_addr}, {1'b1, 1'b1, 4'd1});
    check(ce_addr == 3, "R7", "ce log untouched by ue", ce_addr, 3);

    // R4 injection off: array intact, logs kept
    inj_enable = 1'b0;
    set_mask(39'h3);
    for (int a = 0; a < NW; a++) begin
      do_read(a);
      check(rsp_data == model[a] && !rsp_cerr && !rsp_uerr, "R4", "clean after disable", rsp_data, model[a]);
    end
    @(negedge clk);
    check(ce_flag && ue_flag && ce_addr == 3 && ue_addr == 1, "R5", "logs persist",
          {ce_flag, ue_flag, ce_addr, ue_addr}, {1'b1, 1'b1, 4'd3, 4'd1});

    // R6 clear pulses
    ce_clr = 1'b1; @(negedge clk); ce_clr = 1'b0;
    check(!ce_flag && !ce_irq && ue_flag, "R6", "ce clear", {ce_flag, ce_irq, ue_flag}, 1);
    ue_clr = 1'b1; @(negedge clk); ue_clr = 1'b0;
    check(!ue_flag && !ue_irq, "R6", "ue clear", {ue_flag, ue_irq}, 0);

    // R6 clear coincides with new event
    inj_enable = 1'b1;
    do_read(9);
    @(negedge clk);
    check(ue_flag && ue_addr == 9, "R6", "ue set again", ue_addr, 9);
    do_read(12);
    ue_clr = 1'b1;            // same edge as logging of addr 12
    @(negedge clk);
    ue_clr = 1'b0;
    check(ue_flag && ue_addr == 12, "R6", "clear+hit keeps new", {ue_flag, ue_addr}, {1'b1, 4'd12});
    inj_enable = 1'b0;

    // R8 back-pressure
    rsp_ready = 1'b0;
    do_read(5);
    check(rsp_valid && !req_ready && rsp_data == model[5], "R8", "stalled rsp", rsp_data, model[5]);
    repeat (3) @(negedge clk);
    check(rsp_valid && !req_ready && rsp_data == model[5], "R8", "held rsp", rsp_data, model[5]);
    rsp_ready = 1'b1;
    #1;
    check(req_ready, "R8", "ready with rsp_ready", req_ready, 1);
    @(negedge clk);
    check(!rsp_valid, "R8", "rsp consumed", rsp_valid, 0);

    // R1 rewrite re-encodes
    do_write(7, 32'hDEAD_BEEF);
    do_read(7);
    check(rsp_data == 32'hDEAD_BEEF && !rsp_cerr && !rsp_uerr, "R1", "rewrite", rsp_data, 32'hDEAD_BEEF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule